// File: doc/BRIEF.md
# Indirect-Addressed Serial Management Slave

This block is the management-port slave of a PHY chip that holds several sublayer devices behind one serial management bus. It runs on the management clock, samples the data line on each rising edge, and decodes frames that carry an opcode, a port address and a device address. Register access is indirect. An address frame loads a pointer that belongs to the addressed device. Later write, read and read-with-increment frames use that pointer, and the increment variant advances it after each access. A run of consecutive reads therefore needs one address frame only.

Every device in the chip sees the same small register file:
- a control word whose reset and low-power bits are shared by the whole chip;
- a 32-bit read-only mask of the devices present, split over two consecutive registers;
- zeros at every other address.

Frames in the older direct-access format are dropped without any action. So are frames for another port or for a device that is not present.

The frame decoder is a single state machine with these states:
- ST_PRE: counts preamble ones.
- ST_START: checks the second start bit.
- ST_HDR: shifts in the opcode, port and device fields.
- ST_TA_IN: the turnaround of a write-type frame.
- ST_DATA_IN: shifts in 16 data bits.
- ST_TA_REL: the first turnaround bit of a read, with the line released.
- ST_TA_ZERO: the second turnaround bit of a read, driven low.
- ST_DATA_OUT: shifts out 16 read bits.

The transitions are:
- ST_PRE goes to ST_START on a zero that follows at least 32 ones.
- ST_START goes to ST_HDR on a zero, and back to ST_PRE on a one.
- ST_HDR goes to ST_TA_REL after 12 bits when the frame is a read type and it hits. It goes to ST_TA_IN otherwise.
- ST_TA_IN goes to ST_DATA_IN after 2 bits.
- ST_DATA_IN goes to ST_PRE after 16 bits, and commits the frame on that edge.
- ST_TA_REL goes to ST_TA_ZERO. On this edge the register is captured and the pointer is advanced.
- ST_TA_ZERO goes to ST_DATA_OUT.
- ST_DATA_OUT goes to ST_PRE after 16 bits.

Top module: `mdio_mmd_slave`

## Requirements
- R1: A frame is decoded only after at least 32 consecutive ones followed by the start bits 00. A frame preceded by only 31 ones has no effect.
- R2: A frame whose start bits are 01 causes no register or pointer change and never drives the line (mdio_oe stays 0).
- R3: Opcode 00 (address) loads the 16-bit data field into the pointer of the addressed device. Opcode 11 (read) returns the register at that pointer and leaves the pointer unchanged, so a repeated read returns the same register.
- R4: Opcode 10 (read with increment) returns the register at the pointer and then adds one to the pointer, wrapping from 0xFFFF to 0x0000. Consecutive such frames walk successive registers after a single address frame.
- R5: Each present device keeps its own pointer. An address frame or an increment for one device does not move the pointer of another.
- R6: Opcode 01 (write) writes the register at the pointer and leaves the pointer unchanged. Register 0 is the control word: bit 11 is low power, driven on low_power_o. This state is shared, so a write through any present device is seen through every other.
- R7: Writing a 1 to bit 15 of register 0 through any device pulses chip_reset_o high for exactly one cycle, clears low power, and clears every device pointer to 0. This holds even when bit 11 is set in the same word. Bit 15 reads back as 0.
- R8: Register 5 reads bits 15:0 of the device-present mask and register 6 reads bits 31:16; bit d is set when device address d is present. All other registers read 0. Writes to any register other than 0 have no effect.
- R9: A frame whose port address differs from port_strap, or whose device address is absent from the mask, changes no pointer or register and never drives the line.
- R10: On a read the line is released for the first turnaround bit and driven 0 for the second. The 16 data bits then follow most significant first, and the line is released right after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the data line is sampled and driven from its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Data line value as seen at the pad |
| mdio_o | output | 1 | Data value driven during a read |
| mdio_oe | output | 1 | Output enable for the data line pad |
| port_strap | input | 5 | Port address this chip answers to |
| low_power_o | output | 1 | Chip-wide low-power state from control bit 11 |
| chip_reset_o | output | 1 | One-cycle pulse requesting a reset of all devices |

## Verification
The collision that matters is a control write that sets both the reset bit and the low-power bit in one word. The reset clear and the low-power load then compete for the same register on the same edge, and the pointer clear lands on that edge too. The bench provokes it with a write of 0x8800 to register 0 through one device, while another device holds a nonzero pointer. It judges the result on low_power_o, on the count of chip_reset_o pulses, and on reads through the other device that must now return register 0 instead of the register its old pointer selected.

// File: rtl/mdio_mmd_pkg.sv
package mdio_mmd_pkg;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_START,
        ST_HDR,
        ST_TA_IN,
        ST_DATA_IN,
        ST_TA_REL,
        ST_TA_ZERO,
        ST_DATA_OUT
    } frame_state_e;

    typedef enum logic [1:0] {
        OP_ADDR   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_RD_INC = 2'b10,
        OP_READ   = 2'b11
    } mdio_op_e;

    localparam logic [15:0] ADDR_CTRL    = 16'd0;
    localparam logic [15:0] ADDR_PRES_LO = 16'd5;
    localparam logic [15:0] ADDR_PRES_HI = 16'd6;
    localparam int unsigned CTRL_RST_BIT = 15;
    localparam int unsigned CTRL_LP_BIT  = 11;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mmd_pkg::*;
#(
    parameter int unsigned PORT_W  = 5,
    parameter int unsigned DEV_W   = 5,
    parameter int unsigned REG_W   = 16,
    parameter int unsigned PRE_LEN = 32,
    parameter logic [2*REG_W-1:0] DEV_MASK = 32'h8000_009A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [PORT_W-1:0] port_strap,
    input  logic [REG_W-1:0]  rd_data,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DEV_W-1:0]  dev,
    output logic              hit,
    output logic              ptr_load,
    output logic              ptr_inc,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_data
);
    localparam int unsigned HDR_W   = 2 + PORT_W + DEV_W;
    localparam int unsigned CNT_MAX = (PRE_LEN > REG_W) ? PRE_LEN : REG_W;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(REG_W - 1);
    localparam logic [CNT_W-1:0] TA_LAST  = CNT_W'(1);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [REG_W-1:0] sh_q, sh_d;
    mdio_op_e         op_q, op_d;
    logic [DEV_W-1:0] dev_q, dev_d;
    logic             hit_q, hit_d;
    logic [HDR_W-1:0] hdr_next;
    logic [REG_W-1:0] word_next;

    assign hdr_next  = {sh_q[HDR_W-2:0], mdio_i};
    assign word_next = {sh_q[REG_W-2:0], mdio_i};
    assign wr_data   = word_next;
    assign dev       = dev_q;
    assign hit       = hit_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRE;
            cnt_q   <= '0;
            sh_q    <= '0;
            op_q    <= OP_ADDR;
            dev_q   <= '0;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            op_q    <= op_d;
            dev_q   <= dev_d;
            hit_q   <= hit_d;
        end
    end

    // next state and commit strobes
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        sh_d     = sh_q;
        op_d     = op_q;
        dev_d    = dev_q;
        hit_d    = hit_q;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        wr_en    = 1'b0;
        unique case (state_q)
            ST_PRE: begin
                if (mdio_i) begin
                    if (cnt_q != PRE_CNT) cnt_d = cnt_q + 1'b1;
                end else if (cnt_q == PRE_CNT) begin
                    state_d = ST_START;
                    cnt_d   = '0;
                end else begin
                    cnt_d = '0;
                end
            end
            ST_START: begin
                cnt_d   = '0;
                state_d = mdio_i ? ST_PRE : ST_HDR;
            end
            ST_HDR: begin
                sh_d = word_next;
                if (cnt_q == HDR_LAST) begin
                    op_d  = mdio_op_e'(hdr_next[HDR_W-1 -: 2]);
                    dev_d = hdr_next[DEV_W-1:0];
                    hit_d = (hdr_next[DEV_W +: PORT_W] == port_strap) &&
                            DEV_MASK[hdr_next[DEV_W-1:0]];
                    cnt_d = '0;
                    state_d = (hit_d && hdr_next[HDR_W-1]) ? ST_TA_REL : ST_TA_IN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_TA_IN: begin
                if (cnt_q == TA_LAST) begin
                    state_d = ST_DATA_IN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DATA_IN: begin
                sh_d = word_next;
                if (cnt_q == DAT_LAST) begin
                    state_d  = ST_PRE;
                    cnt_d    = '0;
                    ptr_load = hit_q && (op_q == OP_ADDR);
                    wr_en    = hit_q && (op_q == OP_WRITE);
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_TA_REL: begin
                state_d = ST_TA_ZERO;
                sh_d    = rd_data;
                ptr_inc = (op_q == OP_RD_INC);
            end
            ST_TA_ZERO: begin
                state_d = ST_DATA_OUT;
                cnt_d   = '0;
            end
            ST_DATA_OUT: begin
                sh_d = {sh_q[REG_W-2:0], 1'b0};
                if (cnt_q == DAT_LAST) begin
                    state_d = ST_PRE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_PRE;
        endcase
    end

    // line drive
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state_q)
            ST_TA_ZERO:  mdio_oe = 1'b1;
            ST_DATA_OUT: begin
                mdio_oe = 1'b1;
                mdio_o  = sh_q[REG_W-1];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mdio_ptr_bank.sv
module mdio_ptr_bank #(
    parameter int unsigned DEV_W = 5,
    parameter int unsigned REG_W = 16,
    parameter logic [2*REG_W-1:0] DEV_MASK = 32'h8000_009A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEV_W-1:0] dev,
    input  logic             load,
    input  logic             inc,
    input  logic             clear,
    input  logic [REG_W-1:0] load_val,
    output logic [REG_W-1:0] cur_ptr
);
    localparam int unsigned N_DEV = 1 << DEV_W;

    logic [REG_W-1:0] ptr [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        if (DEV_MASK[g]) begin : g_present
            logic sel;
            assign sel = (dev == DEV_W'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          ptr[g] <= '0;
                else if (clear)      ptr[g] <= '0;
                else if (load && sel) ptr[g] <= load_val;
                else if (inc && sel)  ptr[g] <= ptr[g] + 1'b1;
            end
        end else begin : g_absent
            assign ptr[g] = '0;
        end
    end

    assign cur_ptr = ptr[dev];

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_mmd_pkg::*;
#(
    parameter int unsigned REG_W = 16,
    parameter logic [2*REG_W-1:0] DEV_MASK = 32'h8000_009A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] addr,
    input  logic             wr_en,
    input  logic             wr_rst_bit,
    input  logic             wr_lp_bit,
    output logic [REG_W-1:0] rd_data,
    output logic             reset_req,
    output logic             low_power_o,
    output logic             chip_reset_o
);
    logic ctrl_sel;
    logic low_power_q;
    logic rst_pulse_q;

    assign ctrl_sel  = (addr == ADDR_CTRL);
    assign reset_req = wr_en && ctrl_sel && wr_rst_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_power_q <= 1'b0;
            rst_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q <= reset_req;
            if (reset_req)
                low_power_q <= 1'b0;
            else if (wr_en && ctrl_sel)
                low_power_q <= wr_lp_bit;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_CTRL:    rd_data[CTRL_LP_BIT] = low_power_q;
            ADDR_PRES_LO: rd_data = DEV_MASK[REG_W-1:0];
            ADDR_PRES_HI: rd_data = DEV_MASK[2*REG_W-1:REG_W];
            default:      rd_data = '0;
        endcase
    end

    assign low_power_o  = low_power_q;
    assign chip_reset_o = rst_pulse_q;

endmodule

// File: rtl/mdio_mmd_slave.sv
module mdio_mmd_slave
    import mdio_mmd_pkg::*;
#(
    parameter int unsigned PORT_W  = 5,
    parameter int unsigned DEV_W   = 5,
    parameter int unsigned REG_W   = 16,
    parameter int unsigned PRE_LEN = 32,
    parameter logic [2*REG_W-1:0] DEV_MASK = 32'h8000_009A
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic [PORT_W-1:0] port_strap,
    output logic              low_power_o,
    output logic              chip_reset_o
);
    logic [DEV_W-1:0] dev;
    logic             hit;
    logic             ptr_load;
    logic             ptr_inc;
    logic             wr_en;
    logic [REG_W-1:0] wr_data;
    logic [REG_W-1:0] rd_data;
    logic [REG_W-1:0] cur_ptr;
    logic             reset_req;

    mdio_frame_fsm #(
        .PORT_W(PORT_W), .DEV_W(DEV_W), .REG_W(REG_W),
        .PRE_LEN(PRE_LEN), .DEV_MASK(DEV_MASK)
    ) u_fsm (
        .clk(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .port_strap(port_strap),
        .rd_data(rd_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .dev(dev), .hit(hit), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    mdio_ptr_bank #(
        .DEV_W(DEV_W), .REG_W(REG_W), .DEV_MASK(DEV_MASK)
    ) u_ptrs (
        .clk(mdc), .rst_n(rst_n), .dev(dev), .load(ptr_load), .inc(ptr_inc),
        .clear(reset_req), .load_val(wr_data), .cur_ptr(cur_ptr)
    );

    mdio_regfile #(
        .REG_W(REG_W), .DEV_MASK(DEV_MASK)
    ) u_regs (
        .clk(mdc), .rst_n(rst_n), .addr(cur_ptr), .wr_en(wr_en),
        .wr_rst_bit(wr_data[CTRL_RST_BIT]), .wr_lp_bit(wr_data[CTRL_LP_BIT]),
        .rd_data(rd_data), .reset_req(reset_req),
        .low_power_o(low_power_o), .chip_reset_o(chip_reset_o)
    );

endmodule

// File: rtl/mdio_mmd_slave_chk.sv
module mdio_mmd_slave_chk #(
    parameter int unsigned REG_W = 16
) (
    input logic             mdc,
    input logic             rst_n,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             low_power_o,
    input logic             chip_reset_o,
    input logic             reset_req,
    input logic             ptr_load,
    input logic             ptr_inc,
    input logic             hit,
    input logic [REG_W-1:0] cur_ptr
);
    logic [5:0] oe_run;

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n)       oe_run <= '0;
        else if (mdio_oe) oe_run <= oe_run + 1'b1;
        else              oe_run <= '0;
    end

    // R10: the first driven bit of a read is the low turnaround bit
    p_ta_low_r10: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R10: the line is driven for at most turnaround plus data bits
    p_drive_len_r10: assert property (@(posedge mdc) disable iff (!rst_n)
        oe_run <= 6'(REG_W + 1));

    // R7: the reset pulse lasts a single cycle
    p_rst_pulse_r7: assert property (@(posedge mdc) disable iff (!rst_n)
        chip_reset_o |=> !chip_reset_o);

    // R7: low power is clear whenever the reset pulse is seen
    p_rst_lp_r7: assert property (@(posedge mdc) disable iff (!rst_n)
        chip_reset_o |-> !low_power_o);

    // R7: a reset leaves the selected pointer at zero
    p_rst_ptr_r7: assert property (@(posedge mdc) disable iff (!rst_n)
        reset_req |=> (cur_ptr == '0));

    // R9: pointers move only for frames that hit this chip and device
    p_ptr_hit_r9: assert property (@(posedge mdc) disable iff (!rst_n)
        (ptr_load || ptr_inc) |-> hit);

endmodule

bind mdio_mmd_slave mdio_mmd_slave_chk #(.REG_W(REG_W)) u_chk (
    .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .low_power_o(low_power_o), .chip_reset_o(chip_reset_o),
    .reset_req(reset_req), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
    .hit(hit), .cur_ptr(cur_ptr)
);

// File: tb/mdio_mmd_slave_tb.sv
module mdio_mmd_slave_tb;
    localparam logic [4:0]  STRAP = 5'd5;
    localparam logic [31:0] MASK  = 32'h8000_009A;
    localparam int NV = 23;
    // {req, op, port, dev, data, expected read}
    localparam logic [47:0] VEC [NV] = '{
        {4'd3, 2'b00, 5'd5, 5'd1,  16'h0005, 16'h0000}, // R3 addr dev1 -> 5
        {4'd8, 2'b11, 5'd5, 5'd1,  16'h0000, 16'h009A}, // R8 mask low half
        {4'd3, 2'b11, 5'd5, 5'd1,  16'h0000, 16'h009A}, // R3 pointer retained
        {4'd4, 2'b00, 5'd5, 5'd3,  16'h0005, 16'h0000}, // R4 addr dev3 -> 5
        {4'd4, 2'b10, 5'd5, 5'd3,  16'h0000, 16'h009A}, // R4 inc read reg5
        {4'd4, 2'b10, 5'd5, 5'd3,  16'h0000, 16'h8000}, // R4 inc read reg6
        {4'd8, 2'b10, 5'd5, 5'd3,  16'h0000, 16'h0000}, // R8 reg7 reads zero
        {4'd5, 2'b11, 5'd5, 5'd1,  16'h0000, 16'h009A}, // R5 dev1 unmoved
        {4'd6, 2'b00, 5'd5, 5'd4,  16'h0000, 16'h0000}, // R6 addr dev4 -> 0
        {4'd6, 2'b01, 5'd5, 5'd4,  16'h0800, 16'h0000}, // R6 set low power
        {4'd6, 2'b11, 5'd5, 5'd4,  16'h0000, 16'h0800}, // R6 ptr kept after write
        {4'd6, 2'b00, 5'd5, 5'd1,  16'h0000, 16'h0000}, // R6 addr dev1 -> 0
        {4'd6, 2'b11, 5'd5, 5'd1,  16'h0000, 16'h0800}, // R6 shared via dev1
        {4'd4, 2'b00, 5'd5, 5'd7,  16'hFFFF, 16'h0000}, // R4 addr dev7 -> FFFF
        {4'd4, 2'b10, 5'd5, 5'd7,  16'h0000, 16'h0000}, // R4 read FFFF
        {4'd4, 2'b11, 5'd5, 5'd7,  16'h0000, 16'h0800}, // R4 wrapped to 0
        {4'd8, 2'b00, 5'd5, 5'd31, 16'h0009, 16'h0000}, // R8 addr dev31 -> 9
        {4'd8, 2'b01, 5'd5, 5'd31, 16'hFFFF, 16'h0000}, // R8 write reg9
        {4'd8, 2'b11, 5'd5, 5'd31, 16'h0000, 16'h0000}, // R8 reg9 still zero
        {4'd8, 2'b00, 5'd5, 5'd31, 16'h0006, 16'h0000}, // R8 addr dev31 -> 6
        {4'd8, 2'b11, 5'd5, 5'd31, 16'h0000, 16'h8000}, // R8 mask high half
        {4'd8, 2'b01, 5'd5, 5'd31, 16'h1234, 16'h0000}, // R8 write mask reg
        {4'd8, 2'b11, 5'd5, 5'd31, 16'h0000, 16'h8000}  // R8 mask unchanged
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdio_i = 1'b1;
    logic mdio_o, mdio_oe, low_power_o, chip_reset_o;
    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit drive_seen;
    bit timeout = 0;

    always #2.5 clk = ~clk;

    mdio_mmd_slave #(.DEV_MASK(MASK)) u_dut (
        .mdc(clk), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .port_strap(STRAP), .low_power_o(low_power_o),
        .chip_reset_o(chip_reset_o)
    );

    always @(negedge clk) if (chip_reset_o) pulses++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        drive_seen |= mdio_oe;
        mdio_i = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic frame(input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] port, input logic [4:0] dev,
                         input logic [15:0] data, input int pre,
                         output logic [15:0] rd, output bit fmt_ok);
        drive_seen = 0;
        fmt_ok = 1;
        rd = '0;
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(st[1]); send_bit(st[0]);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(port[i]);
        for (int i = 4; i >= 0; i--) send_bit(dev[i]);
        if (op[1]) begin
            @(negedge clk); mdio_i = 1'b1;
            drive_seen |= mdio_oe;
            if (mdio_oe) fmt_ok = 0;
            @(negedge clk);
            drive_seen |= mdio_oe;
            if (!(mdio_oe && !mdio_o)) fmt_ok = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                drive_seen |= mdio_oe;
                if (!mdio_oe) fmt_ok = 0;
                rd = {rd[14:0], mdio_o};
            end
            @(negedge clk);
            drive_seen |= mdio_oe;
            if (mdio_oe) fmt_ok = 0;
        end else begin
            send_bit(1'b1); send_bit(1'b0);
            for (int i = 15; i >= 0; i--) send_bit(data[i]);
        end
    endtask

    task automatic run_all();
        logic [15:0] rd;
        bit ok;
        int c0;
        // reset state
        chk(mdio_oe == 1'b0, "R10", "oe after reset", 32'(mdio_oe), 0);
        chk(low_power_o == 1'b0, "R6", "low power after reset", 32'(low_power_o), 0);
        chk(chip_reset_o == 1'b0, "R7", "reset pulse after reset", 32'(chip_reset_o), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            frame(2'b00, VEC[v][43:42], VEC[v][41:37], VEC[v][36:32],
                  VEC[v][31:16], 32, rd, ok);
            if (VEC[v][43]) begin
                chk(ok, "R10", $sformatf("read timing vec %0d", v), 32'(ok), 1);
                chk(rd == VEC[v][15:0], $sformatf("R%0d", VEC[v][47:44]),
                    $sformatf("read data vec %0d", v), 32'(rd), 32'(VEC[v][15:0]));
            end
        end
        idle(2);
        chk(low_power_o == 1'b1, "R6", "low power pin", 32'(low_power_o), 1);

        // R9: wrong port and absent device
        frame(2'b00, 2'b00, 5'd6, 5'd1, 16'h0005, 32, rd, ok);
        chk(!drive_seen, "R9", "wrong port addr drive", 32'(drive_seen), 0);
        frame(2'b00, 2'b11, 5'd6, 5'd1, 16'h0000, 32, rd, ok);
        chk(!drive_seen, "R9", "wrong port read drive", 32'(drive_seen), 0);
        frame(2'b00, 2'b11, 5'd5, 5'd2, 16'h0000, 32, rd, ok);
        chk(!drive_seen, "R9", "absent device read drive", 32'(drive_seen), 0);
        frame(2'b00, 2'b11, 5'd5, 5'd1, 16'h0000, 32, rd, ok);
        chk(rd == 16'h0800, "R9", "dev1 ptr after ignored addr", 32'(rd), 32'h0800);

        // R2: start 01 frames
        frame(2'b01, 2'b01, 5'd5, 5'd1, 16'h0000, 32, rd, ok);
        chk(!drive_seen, "R2", "start01 write drive", 32'(drive_seen), 0);
        idle(2);
        chk(low_power_o == 1'b1, "R2", "start01 write ignored", 32'(low_power_o), 1);
        frame(2'b01, 2'b11, 5'd5, 5'd1, 16'h0000, 32, rd, ok);
        chk(!drive_seen, "R2", "start01 read drive", 32'(drive_seen), 0);

        // R1: short preamble ignored, full preamble accepted
        send_bit(1'b0);
        frame(2'b00, 2'b01, 5'd5, 5'd1, 16'h0000, 31, rd, ok);
        idle(2);
        chk(low_power_o == 1'b1, "R1", "31-bit preamble ignored", 32'(low_power_o), 1);
        send_bit(1'b0);
        frame(2'b00, 2'b01, 5'd5, 5'd1, 16'h0000, 32, rd, ok);
        idle(2);
        chk(low_power_o == 1'b0, "R1", "32-bit preamble accepted", 32'(low_power_o), 0);

        // R7: reset and low power in one word, pointers cleared
        frame(2'b00, 2'b00, 5'd5, 5'd3, 16'h0006, 32, rd, ok);
        frame(2'b00, 2'b01, 5'd5, 5'd1, 16'h0800, 32, rd, ok);
        idle(2);
        chk(low_power_o == 1'b1, "R6", "low power set again", 32'(low_power_o), 1);
        c0 = pulses;
        frame(2'b00, 2'b01, 5'd5, 5'd4, 16'h8800, 32, rd, ok);
        idle(3);
        chk(pulses == c0 + 1, "R7", "reset pulse count", 32'(pulses - c0), 1);
        chk(low_power_o == 1'b0, "R7", "reset wins over low power", 32'(low_power_o), 0);
        frame(2'b00, 2'b11, 5'd5, 5'd3, 16'h0000, 32, rd, ok);
        chk(rd == 16'h0000, "R7", "dev3 ptr cleared", 32'(rd), 0);
        frame(2'b00, 2'b11, 5'd5, 5'd31, 16'h0000, 32, rd, ok);
        chk(rd == 16'h0000, "R7", "dev31 ptr cleared", 32'(rd), 0);
        frame(2'b00, 2'b10, 5'd5, 5'd1, 16'h0000, 32, rd, ok);
        chk(rd == 16'h0000, "R7", "reset bit reads zero", 32'(rd), 0);
        frame(2'b00, 2'b11, 5'd5, 5'd1, 16'h0000, 32, rd, ok);
        chk(rd == 16'h0000, "R4", "dev1 ptr now 1", 32'(rd), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule